// File: doc/BRIEF.md
# Interconnect Agent Error Logger

This block sits beside one agent of an on-chip interconnect, whether that agent fronts an initiator or a target. When the agent reports a failed transaction, the block builds a 32-bit attribute word from three inputs: the request-info sideband, the 3-bit OCP command, and the cause flags. It stores that word together with the faulting address. It then sets a sticky error bit in its status register and drives an error-pending line toward the chip-level error aggregator.

The first error is held until software clears the status bit. Software reads and clears the logged error through a small 64-bit register window that spans 1 KiB. A build parameter selects a reduced mode for simple memories, in which every logged attribute reads as the bare address-hole code.

Top module: `agent_err_capture`

## Requirements
- R1: The logged attribute carries request-info bits [15:7] in attribute bits [31:23] and request-info bits [5:0] (the low six bits of the bus master ID) in attribute bits [21:16].
- R2: Attribute bit 3 is the burst-error flag, bit 2 the register-permission flag and bit 0 the address-hole flag; attribute bits 22, 15:11, 7:4 and 1 are always zero.
- R3: Attribute bits [10:8] carry the 3-bit OCP command unchanged, with this encoding: 0 idle, 1 write, 2 read, 3 exclusive read, 4 linked read, 5 non-posted write, 6 conditional write, 7 broadcast.
- R4: An error event sets status bit 24 on the next clock edge. The `err_pending` output always equals status bit 24.
- R5: While status bit 24 is set, further error events are dropped. The logged attribute and address keep their first values.
- R6: A write of 1 in data bit 24 to the status offset clears the error bit. A write with data bit 24 at 0, and all other data bits, have no effect.
- R7: An error event in the same cycle as a clearing write is captured: the new attribute and address are logged and bit 24 stays set.
- R8: Register offsets are: status 0x28, attribute log 0x58 (attribute in bits [31:0], upper bits zero), and logged address 0x60 (zero-extended). Reads of any other offset return zero. Writes to any offset other than a status clear change nothing.
- R9: With the address-hole-only parameter set, every logged attribute reads as 0x1, whatever the inputs.
- R10: Synchronous active-high reset clears the status, the log, the address and `err_pending`. Read data is registered and appears one cycle after the offset is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Agent reports a failed transaction this cycle |
| err_reqinfo | input | 16 | Request-info sideband of the failed transaction |
| err_cmd | input | 3 | OCP command of the failed transaction |
| err_burst | input | 1 | Cause: burst access error |
| err_perm | input | 1 | Cause: register permission error |
| err_hole | input | 1 | Cause: address hole (invalid address) |
| err_addr | input | ADDR_W | Faulting address |
| reg_addr | input | 10 | Byte offset into the register window |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data for `reg_addr` |
| err_pending | output | 1 | Error logged, toward the aggregator |

## Verification
A new error event and a software clear can arrive in the same cycle. The bench provokes this by asserting `err_valid` with fresh attribute inputs in the very cycle it writes bit 24 to the status offset, while an older error is still held. It then judges the outcome at the ports: `err_pending` must stay high, and the log and address offsets must return the new event, not the old one. The opposite pairing is also covered: a second error while the first is held, with no clear, must leave the first entry intact.

// File: rtl/agent_err_pkg.sv
package agent_err_pkg;

  localparam int REG_W   = 64;
  localparam int OFS_W   = 10;
  localparam int INFO_W  = 16;
  localparam int ERR_BIT = 24;

  localparam logic [OFS_W-1:0] OFS_STATUS = 10'h028;
  localparam logic [OFS_W-1:0] OFS_LOG    = 10'h058;
  localparam logic [OFS_W-1:0] OFS_ADDR   = 10'h060;

  typedef enum logic [2:0] {
    CMD_IDLE   = 3'd0,
    CMD_WR     = 3'd1,
    CMD_RD     = 3'd2,
    CMD_RD_EX  = 3'd3,
    CMD_RD_LNK = 3'd4,
    CMD_WR_NP  = 3'd5,
    CMD_WR_CND = 3'd6,
    CMD_BCAST  = 3'd7
  } ocp_cmd_e;

  typedef struct packed {
    logic [8:0] info_hi;   // [31:23]
    logic       rsv22;     // [22]
    logic [5:0] master;    // [21:16]
    logic [4:0] rsv15_11;  // [15:11]
    logic [2:0] cmd;       // [10:8]
    logic [3:0] rsv7_4;    // [7:4]
    logic       burst;     // [3]
    logic       perm;      // [2]
    logic       rsv1;      // [1]
    logic       hole;      // [0]
  } err_attr_t;

endpackage

// File: rtl/agent_err_attr.sv
module agent_err_attr
  import agent_err_pkg::*;
#(
  parameter bit HOLE_ONLY = 1'b0
) (
  input  logic [INFO_W-1:0] info,
  input  logic [2:0]        cmd,
  input  logic              burst,
  input  logic              perm,
  input  logic              hole,
  output err_attr_t         attr
);

  generate
    if (HOLE_ONLY) begin : g_hole
      always_comb begin
        attr      = '0;
        attr.hole = 1'b1;
      end
    end else begin : g_full
      always_comb begin
        attr         = '0;
        attr.info_hi = info[INFO_W-1:7];
        attr.master  = info[5:0];
        attr.cmd     = cmd;
        attr.burst   = burst;
        attr.perm    = perm;
        attr.hole    = hole;
      end
    end
  endgenerate

endmodule

// File: rtl/agent_err_log.sv
module agent_err_log
  import agent_err_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  err_attr_t         ev_attr,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              clr,
  output logic              flag_q,
  output err_attr_t         attr_q,
  output logic [ADDR_W-1:0] addr_q
);

  logic take;
  assign take = ev_valid && (!flag_q || clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      attr_q <= '0;
      addr_q <= '0;
    end else if (take) begin
      flag_q <= 1'b1;
      attr_q <= ev_attr;
      addr_q <= ev_addr;
    end else if (clr) begin
      flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/agent_err_regs.sv
module agent_err_regs
  import agent_err_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic              flag,
  input  err_attr_t         attr,
  input  logic [ADDR_W-1:0] eaddr,
  output logic              clr,
  output logic [REG_W-1:0]  rdata
);

  localparam int PAD_W = REG_W - ADDR_W;

  assign clr = wr_en && (ofs == OFS_STATUS) && wdata[ERR_BIT];

  logic [REG_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    case (ofs)
      OFS_STATUS: rd_next[ERR_BIT] = flag;
      OFS_LOG:    rd_next[31:0]    = attr;
      OFS_ADDR:   rd_next          = {{PAD_W{1'b0}}, eaddr};
      default:    rd_next          = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/agent_err_capture.sv
module agent_err_capture
  import agent_err_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit HOLE_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_valid,
  input  logic [15:0]       err_reqinfo,
  input  logic [2:0]        err_cmd,
  input  logic              err_burst,
  input  logic              err_perm,
  input  logic              err_hole,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [9:0]        reg_addr,
  input  logic              reg_wr_en,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              err_pending
);

  err_attr_t         ev_attr;
  err_attr_t         attr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              flag_q;
  logic              clr_hit;

  agent_err_attr #(.HOLE_ONLY(HOLE_ONLY)) u_attr (
    .info  (err_reqinfo),
    .cmd   (err_cmd),
    .burst (err_burst),
    .perm  (err_perm),
    .hole  (err_hole),
    .attr  (ev_attr)
  );

  agent_err_log #(.ADDR_W(ADDR_W)) u_log (
    .clk      (clk),
    .rst      (rst),
    .ev_valid (err_valid),
    .ev_attr  (ev_attr),
    .ev_addr  (err_addr),
    .clr      (clr_hit),
    .flag_q   (flag_q),
    .attr_q   (attr_q),
    .addr_q   (addr_q)
  );

  agent_err_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .ofs   (reg_addr),
    .wr_en (reg_wr_en),
    .wdata (reg_wdata),
    .flag  (flag_q),
    .attr  (attr_q),
    .eaddr (addr_q),
    .clr   (clr_hit),
    .rdata (reg_rdata)
  );

  assign err_pending = flag_q;

endmodule

// File: rtl/agent_err_capture_chk.sv
module agent_err_capture_chk #(
  parameter int ADDR_W    = 32,
  parameter bit HOLE_ONLY = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              err_valid,
  input logic              clr_hit,
  input logic              err_pending,
  input logic [31:0]       attr_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [9:0]        reg_addr,
  input logic              reg_wr_en,
  input logic [63:0]       reg_rdata
);

  logic undef_ofs;
  assign undef_ofs = (reg_addr != 10'h028) && (reg_addr != 10'h058) && (reg_addr != 10'h060);

  // R4: the pending line only rises after an error event
  p_rise_needs_event_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(err_pending) |-> $past(err_valid));

  // R5: a held entry is not overwritten without a clear
  p_hold_first_r5: assert property (@(posedge clk) disable iff (rst)
    (err_pending && !clr_hit) |=> ($stable(attr_q) && $stable(addr_q) && err_pending));

  // R6: a clear with no competing event drops the pending line
  p_clear_drops_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !err_valid) |=> !err_pending);

  // R7: any event leaves the pending line set, even against a clear
  p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> err_pending);

  // R8: undefined offsets read back as zero
  p_undef_zero_r8: assert property (@(posedge clk) disable iff (rst)
    undef_ofs |=> (reg_rdata == 64'd0));

  // R9: reduced mode logs only the hole code
  p_hole_only_r9: assert property (@(posedge clk) disable iff (rst)
    (HOLE_ONLY && err_pending) |-> (attr_q == 32'h1));

endmodule

bind agent_err_capture agent_err_capture_chk #(.ADDR_W(ADDR_W), .HOLE_ONLY(HOLE_ONLY)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .err_valid   (err_valid),
  .clr_hit     (clr_hit),
  .err_pending (err_pending),
  .attr_q      (attr_q),
  .addr_q      (addr_q),
  .reg_addr    (reg_addr),
  .reg_wr_en   (reg_wr_en),
  .reg_rdata   (reg_rdata)
);

// File: tb/agent_err_capture_tb.sv
`timescale 1ns/1ps
module agent_err_capture_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        err_valid = 1'b0;
  logic [15:0] err_reqinfo = '0;
  logic [2:0]  err_cmd = '0;
  logic        err_burst = 1'b0, err_perm = 1'b0, err_hole = 1'b0;
  logic [31:0] err_addr = '0;
  logic [9:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata, hole_rdata;
  logic        err_pending, hole_pending;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  agent_err_capture u_dut (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_reqinfo(err_reqinfo),
    .err_cmd(err_cmd), .err_burst(err_burst), .err_perm(err_perm), .err_hole(err_hole),
    .err_addr(err_addr), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_pending(err_pending)
  );

  agent_err_capture #(.HOLE_ONLY(1'b1)) u_hole (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_reqinfo(err_reqinfo),
    .err_cmd(err_cmd), .err_burst(err_burst), .err_perm(err_perm), .err_hole(err_hole),
    .err_addr(err_addr), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(hole_rdata), .err_pending(hole_pending)
  );

  function automatic logic [63:0] exp_attr(input logic [15:0] info, input logic [2:0] cmd,
                                           input logic [2:0] cause);
    logic [31:0] a;
    a = {info[15:7], 1'b0, info[5:0], 5'b0, cmd, 4'b0, cause[2], cause[1], 1'b0, cause[0]};
    return {32'd0, a};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_err(input logic [15:0] info, input logic [2:0] cmd,
                           input logic [2:0] cause, input logic [31:0] addr);
    err_valid = 1'b1; err_reqinfo = info; err_cmd = cmd;
    err_burst = cause[2]; err_perm = cause[1]; err_hole = cause[0]; err_addr = addr;
  endtask

  task automatic inject(input logic [15:0] info, input logic [2:0] cmd,
                        input logic [2:0] cause, input logic [31:0] addr);
    @(negedge clk);
    drive_err(info, cmd, cause, addr);
    @(negedge clk);
    err_valid = 1'b0;
  endtask

  task automatic rd(input logic [9:0] ofs, output logic [63:0] d, output logic [63:0] dh);
    @(negedge clk);
    reg_addr = ofs;
    @(negedge clk);
    d = reg_rdata;
    dh = hole_rdata;
  endtask

  task automatic wr(input logic [9:0] ofs, input logic [63:0] data);
    @(negedge clk);
    reg_addr = ofs; reg_wr_en = 1'b1; reg_wdata = data;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] d, dh;
    logic [15:0] info;
    logic [31:0] ad;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    check("R10 pending after reset", {63'd0, err_pending}, 64'd0);
    rd(10'h028, d, dh); check("R10 status after reset", d, 64'd0);
    rd(10'h058, d, dh); check("R10 log after reset", d, 64'd0);
    rd(10'h060, d, dh); check("R10 addr after reset", d, 64'd0);

    // R1 R2 R3 R4 R6 R9: sweep every command and cause combination
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 8; k++) begin
        info = 16'((c * 8 + k) * 40503 + 16'h5a3c);
        ad   = 32'h8000_0000 + 32'((c * 8 + k) * 1237);
        inject(info, 3'(c), 3'(k), ad);
        check("R4 pending set", {63'd0, err_pending}, 64'd1);
        rd(10'h058, d, dh);
        check("R1 R2 R3 attribute", d, exp_attr(info, 3'(c), 3'(k)));
        check("R9 hole-only attribute", dh, 64'd1);
        rd(10'h060, d, dh);
        check("R8 logged address", d, {32'd0, ad});
        rd(10'h028, d, dh);
        check("R4 status bit", d, 64'h0000_0000_0100_0000);
        wr(10'h028, 64'h0000_0000_0100_0000);
        check("R6 cleared", {63'd0, err_pending}, 64'd0);
        rd(10'h028, d, dh);
        check("R6 status cleared", d, 64'd0);
      end
    end

    // R5: second error dropped
    inject(16'hffff, 3'd2, 3'b001, 32'h1111_0000);
    inject(16'h0000, 3'd7, 3'b100, 32'h2222_0000);
    rd(10'h058, d, dh); check("R5 first attribute kept", d, exp_attr(16'hffff, 3'd2, 3'b001));
    rd(10'h060, d, dh); check("R5 first address kept", d, 64'h1111_0000);

    // R6: non-clearing writes
    wr(10'h028, 64'd0);
    check("R6 zero write keeps", {63'd0, err_pending}, 64'd1);
    wr(10'h028, ~64'h0000_0000_0100_0000);
    check("R6 other bits keep", {63'd0, err_pending}, 64'd1);

    // R8: undefined offsets and ignored writes
    rd(10'h000, d, dh); check("R8 undef 0x000", d, 64'd0);
    rd(10'h030, d, dh); check("R8 undef 0x030", d, 64'd0);
    rd(10'h3f8, d, dh); check("R8 undef 0x3f8", d, 64'd0);
    wr(10'h058, '1);
    wr(10'h060, '1);
    wr(10'h020, '1);
    check("R8 stray writes keep pending", {63'd0, err_pending}, 64'd1);
    rd(10'h058, d, dh); check("R8 log not writable", d, exp_attr(16'hffff, 3'd2, 3'b001));
    rd(10'h060, d, dh); check("R8 addr not writable", d, 64'h1111_0000);

    // R7: event and clear in the same cycle
    @(negedge clk);
    drive_err(16'h3c81, 3'd5, 3'b110, 32'h3333_0044);
    reg_addr = 10'h028; reg_wr_en = 1'b1; reg_wdata = 64'h0000_0000_0100_0000;
    @(negedge clk);
    err_valid = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
    check("R7 pending stays", {63'd0, err_pending}, 64'd1);
    rd(10'h058, d, dh); check("R7 new attribute", d, exp_attr(16'h3c81, 3'd5, 3'b110));
    rd(10'h060, d, dh); check("R7 new address", d, 64'h3333_0044);
    rd(10'h028, d, dh); check("R7 status set", d, 64'h0000_0000_0100_0000);

    // R7: event and clear with nothing held
    wr(10'h028, 64'h0000_0000_0100_0000);
    @(negedge clk);
    drive_err(16'h0081, 3'd1, 3'b000, 32'h0000_0abc);
    reg_addr = 10'h028; reg_wr_en = 1'b1; reg_wdata = 64'h0000_0000_0100_0000;
    @(negedge clk);
    err_valid = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
    check("R7 idle case pending", {63'd0, err_pending}, 64'd1);
    rd(10'h058, d, dh); check("R7 idle case attribute", d, exp_attr(16'h0081, 3'd1, 3'b000));

    // R10: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 pending after mid reset", {63'd0, err_pending}, 64'd0);
    rd(10'h058, d, dh); check("R10 log after mid reset", d, 64'd0);

    finish_run();
  end

endmodule